// File: doc/BRIEF.md
# Dual-Channel Serial Converter Register Front End

This block is the digital side of a two-channel digital-to-analog converter. A host writes it through a three-wire serial link made of a data line, a serial clock and an active-low select. While select is low, bits enter a shift register. When select returns high, the block looks at the last 18 bits it received, decodes a two-bit channel address, and writes a 16-bit code into one channel's input register, into both, or into neither.

A second level of registers, the output registers, drives the converters. Pulsing the active-low load input copies both input registers into the output registers on the same clock edge, so the two channels change together. If the load input is held low, each output follows its input register. An asynchronous active-low reset sets every code register to zero or to midscale, depending on the level of a preset-select pin.

All serial inputs and the load input are sampled through a two-stage synchronizer clocked by the system clock. Edges are then detected on the synchronized copies.

Top module: `dual_dac_front`

## Requirements
- R1: A frame is 18 bits, shifted most significant bit first. Frame bits 17:16 are the channel address and bits 15:0 are the code.
- R2: When select rises, only the 18 most recently shifted bits are used. Any bits shifted earlier in the same select-low period are discarded.
- R3: A rising edge of synchronized select writes the code into the addressed input registers. The output registers keep their values while load is high.
- R4: Address bit 0 enables channel A and address bit 1 enables channel B. So 00 writes nothing, 01 writes A, 10 writes B and 11 writes both.
- R5: While synchronized load is low, each clock edge copies both input registers into their output registers on the same edge.
- R6: When load is held low, each output tracks its input register one clock later.
- R7: Serial clock rising edges shift in data only while synchronized select is low. Edges seen while select is high leave the shift register unchanged.
- R8: An asynchronous reset (rst_n low) presets every input and output register to 0x0000 when preset_mid is low and to 0x8000 when it is high.
- R9: A reset during a partial frame clears the shift register. No frame data from before the reset reaches any code register.
- R10: Each input passes through two synchronizer flops. The input register is written on the edge after synchronized select is first seen high. With load low, the output register follows on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| preset_mid | input | 1 | Reset code select: 1 gives midscale 0x8000, 0 gives 0x0000 |
| ser_cs_n | input | 1 | Serial select, active low; its rising edge loads the frame |
| ser_sclk | input | 1 | Serial bit clock; data is taken on its rising edge |
| ser_din | input | 1 | Serial data, most significant bit first |
| load_n | input | 1 | Active-low transfer of input registers into output registers |
| dac_a | output | 16 | Channel A output register |
| dac_b | output | 16 | Channel B output register |

## Verification
A fault in the shift register or the address decode stays hidden until the next load transfer. At that point the wrong code appears on dac_a or dac_b, four to five clocks after select rises when load is held low. A synchronizer that is too short or too long, or a misplaced edge detector, moves the output change by whole clock cycles. The bench compares the outputs against a behavioural model on every clock, so that shift shows up at once. A register that resets to the wrong preset shows at the ports on the first clock after reset.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  localparam int CODE_BITS = 16;
  localparam int ADDR_BITS = 2;
  localparam int SYNC_DEPTH = 2;

  // one address bit per channel: bit i enables channel i
  function automatic logic [ADDR_BITS-1:0] chan_select(input logic [ADDR_BITS-1:0] addr);
    logic [ADDR_BITS-1:0] m;
    for (int i = 0; i < ADDR_BITS; i++) m[i] = addr[i];
    return m;
  endfunction

  // reset code: midscale is only the top bit set
  function automatic logic [CODE_BITS-1:0] preset_code(input logic mid);
    logic [CODE_BITS-1:0] c;
    c = '0;
    c[CODE_BITS-1] = mid;
    return c;
  endfunction
endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dacfe_shifter.sv
module dacfe_shifter #(
  parameter int FRAME_W = 18
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n_s,
  input  logic               sclk_s,
  input  logic               din_s,
  output logic [FRAME_W-1:0] frame,
  output logic               load_stb
);
  logic               cs_q;
  logic               sclk_q;
  logic [FRAME_W-1:0] sr;
  logic               sclk_rise;
  logic               shift_en;

  assign sclk_rise = sclk_s & ~sclk_q;
  assign shift_en  = sclk_rise & ~cs_n_s;
  assign load_stb  = cs_n_s & ~cs_q;
  assign frame     = sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
      sr     <= '0;
    end else begin
      cs_q   <= cs_n_s;
      sclk_q <= sclk_s;
      if (shift_en) sr <= {sr[FRAME_W-2:0], din_s};
    end
  end

  // R3: the frame load strobe is a single-cycle pulse
  p_strobe_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> !load_stb);

  // R7: nothing enters the shift register while select is high
  p_shift_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> $stable(sr));
endmodule

// File: rtl/dacfe_chan.sv
module dacfe_chan #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] preset,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         ld_n_s,
  output logic [W-1:0] in_q,
  output logic [W-1:0] dac_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q  <= preset;
      dac_q <= preset;
    end else begin
      if (wr_en)   in_q  <= wr_data;
      if (!ld_n_s) dac_q <= in_q;
    end
  end

  // R5: output register holds while load is high
  p_dac_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ld_n_s |=> $stable(dac_q));

  // R6: with load low the output takes the previous input value
  p_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_n_s |=> (dac_q == $past(in_q)));
endmodule

// File: rtl/dual_dac_front.sv
module dual_dac_front
  import dacfe_pkg::*;
#(
  parameter int DATA_W = dacfe_pkg::CODE_BITS,
  parameter int ADDR_W = dacfe_pkg::ADDR_BITS,
  parameter int SYNC_STAGES = dacfe_pkg::SYNC_DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              preset_mid,
  input  logic              ser_cs_n,
  input  logic              ser_sclk,
  input  logic              ser_din,
  input  logic              load_n,
  output logic [DATA_W-1:0] dac_a,
  output logic [DATA_W-1:0] dac_b
);
  localparam int FRAME_W = ADDR_W + DATA_W;
  localparam int NCH = ADDR_W;
  // synchronized bundle order: {load_n, din, sclk, cs_n}
  localparam logic [3:0] IDLE_LVL = 4'b1001;

  logic [3:0]         raw_in;
  logic [3:0]         syn;
  logic               cs_n_s, sclk_s, din_s, ld_n_s;
  logic [FRAME_W-1:0] frame;
  logic               load_stb;
  logic [ADDR_W-1:0]  frame_addr;
  logic [DATA_W-1:0]  frame_code;
  logic [NCH-1:0]     wr_mask;
  logic [DATA_W-1:0]  preset;
  logic [DATA_W-1:0]  in_w  [NCH];
  logic [DATA_W-1:0]  dac_w [NCH];

  assign raw_in = {load_n, ser_din, ser_sclk, ser_cs_n};

  dacfe_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(IDLE_LVL)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn));

  assign {ld_n_s, din_s, sclk_s, cs_n_s} = syn;

  dacfe_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .sclk_s(sclk_s),
    .din_s(din_s), .frame(frame), .load_stb(load_stb));

  assign frame_addr = frame[FRAME_W-1:DATA_W];
  assign frame_code = frame[DATA_W-1:0];
  assign wr_mask    = load_stb ? chan_select(frame_addr) : '0;
  assign preset     = preset_code(preset_mid);

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    dacfe_chan #(.W(DATA_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .preset(preset), .wr_en(wr_mask[c]),
      .wr_data(frame_code), .ld_n_s(ld_n_s),
      .in_q(in_w[c]), .dac_q(dac_w[c]));
  end

  assign dac_a = dac_w[0];
  assign dac_b = dac_w[1];

  // R4: address 00 leaves both input registers untouched
  p_addr_none_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_stb && frame_addr == '0) |=> ($stable(in_w[0]) && $stable(in_w[1])));

  // R3: input registers change only on a load strobe
  p_in_write_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !load_stb |=> ($stable(in_w[0]) && $stable(in_w[1])));
endmodule

// File: tb/dual_dac_front_tb.sv
`timescale 1ns/1ps
module dual_dac_front_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic preset_mid = 1'b0;
  logic ser_cs_n = 1'b1;
  logic ser_sclk = 1'b0;
  logic ser_din = 1'b0;
  logic load_n = 1'b1;
  logic [15:0] dac_a, dac_b;

  int n_checks = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  dual_dac_front dut_i (
    .clk(clk), .rst_n(rst_n), .preset_mid(preset_mid), .ser_cs_n(ser_cs_n),
    .ser_sclk(ser_sclk), .ser_din(ser_din), .load_n(load_n),
    .dac_a(dac_a), .dac_b(dac_b));

  // behavioural reference: input history queue of {load_n, din, sclk, cs_n}
  logic [3:0]  hist[$];
  logic [15:0] m_in_a, m_in_b, m_out_a, m_out_b;
  logic [17:0] m_sr;

  function automatic logic [15:0] m_preset(input logic mid);
    return mid ? 16'h8000 : 16'h0000;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_in_a = m_preset(preset_mid); m_in_b = m_in_a;
      m_out_a = m_in_a; m_out_b = m_in_a;
      m_sr = '0;
      hist = '{4'b1001, 4'b1001, 4'b1001};
    end else begin
      logic [3:0] now_s, prev_s;
      now_s = hist[1];
      prev_s = hist[2];
      if (!now_s[3]) begin m_out_a = m_in_a; m_out_b = m_in_b; end
      if (now_s[0] && !prev_s[0]) begin
        if (m_sr[16]) m_in_a = m_sr[15:0];
        if (m_sr[17]) m_in_b = m_sr[15:0];
      end
      if (now_s[1] && !prev_s[1] && !now_s[0]) m_sr = {m_sr[16:0], now_s[2]};
      hist.push_front({load_n, ser_din, ser_sclk, ser_cs_n});
      void'(hist.pop_back());
    end
  end

  // R10: cycle-exact comparison on every clock
  always @(negedge clk) begin
    if (rst_n) begin
      n_checks++;
      if (dac_a !== m_out_a || dac_b !== m_out_b) begin
        n_fail++;
        $display("FAIL R10 cycle model: got a=%h b=%h exp a=%h b=%h",
                 dac_a, dac_b, m_out_a, m_out_b);
      end
    end
  end

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [31:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_din = bits[i];
      idle(3);
      ser_sclk = 1'b1;
      idle(3);
      ser_sclk = 1'b0;
    end
  endtask

  task automatic frame(input logic [1:0] addr, input logic [15:0] code);
    ser_cs_n = 1'b0; idle(3);
    send_bits({14'd0, addr, code}, 18);
    idle(3); ser_cs_n = 1'b1; idle(8);
  endtask

  task automatic ld_pulse();
    load_n = 1'b0; idle(3); load_n = 1'b1; idle(6);
  endtask

  task automatic do_reset(input logic mid);
    @(negedge clk);
    preset_mid = mid; rst_n = 1'b0;
    ser_cs_n = 1'b1; ser_sclk = 1'b0; ser_din = 1'b0; load_n = 1'b1;
    idle(1);
    check("R8 reset code a", dac_a, mid ? 16'h8000 : 16'h0000);
    check("R8 reset code b", dac_b, mid ? 16'h8000 : 16'h0000);
    idle(2); rst_n = 1'b1; idle(4);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    summary();
  end

  initial begin
    idle(2);
    do_reset(1'b0);

    frame(2'b01, 16'h1234);
    check("R3 output held while load high", dac_a, 16'h0000);
    ld_pulse();
    check("R3 addr 01 writes A", dac_a, 16'h1234);
    check("R4 addr 01 leaves B", dac_b, 16'h0000);

    frame(2'b10, 16'hBEEF);
    frame(2'b01, 16'h0F0F);
    check("R5 pending a", dac_a, 16'h1234);
    check("R5 pending b", dac_b, 16'h0000);
    ld_pulse();
    check("R5 joint update a", dac_a, 16'h0F0F);
    check("R5 joint update b", dac_b, 16'hBEEF);

    frame(2'b11, 16'h5A5A); ld_pulse();
    check("R4 addr 11 a", dac_a, 16'h5A5A);
    check("R4 addr 11 b", dac_b, 16'h5A5A);

    frame(2'b00, 16'hFFFF); ld_pulse();
    check("R4 addr 00 a", dac_a, 16'h5A5A);
    check("R4 addr 00 b", dac_b, 16'h5A5A);

    // R2: four leading junk bits, then addr 10 code 00C3
    ser_cs_n = 1'b0; idle(3);
    send_bits({10'd0, 4'b1111, 2'b10, 16'h00C3}, 22);
    idle(3); ser_cs_n = 1'b1; idle(8); ld_pulse();
    check("R2 last 18 bits b", dac_b, 16'h00C3);
    check("R2 last 18 bits a", dac_a, 16'h5A5A);

    frame(2'b01, 16'h8001); ld_pulse();
    check("R1 msb-first code", dac_a, 16'h8001);

    // R7: clock edges with select high, then an empty select pulse
    ser_din = 1'b1;
    for (int i = 0; i < 18; i++) begin
      idle(3); ser_sclk = 1'b1; idle(3); ser_sclk = 1'b0;
    end
    ser_din = 1'b0;
    ser_cs_n = 1'b0; idle(4); ser_cs_n = 1'b1; idle(8); ld_pulse();
    check("R7 ignored edges a", dac_a, 16'h8001);
    check("R7 ignored edges b", dac_b, 16'h00C3);

    load_n = 1'b0;
    frame(2'b10, 16'h7777);
    check("R6 transparent b", dac_b, 16'h7777);
    frame(2'b01, 16'h0101);
    check("R6 transparent a", dac_a, 16'h0101);
    load_n = 1'b1; idle(4);

    // R9: reset in the middle of a frame, midscale preset
    ser_cs_n = 1'b0; idle(3);
    send_bits({22'd0, 10'h3FF}, 10);
    do_reset(1'b1);
    ld_pulse();
    check("R9 partial frame dropped a", dac_a, 16'h8000);
    check("R9 partial frame dropped b", dac_b, 16'h8000);

    idle(4);
    summary();
  end
endmodule